// File: doc/BRIEF.md
# Weighted-free digital CDS pixel accumulator

This block turns a stream of 12-bit ADC conversions of a CCD video waveform into one pixel value per pixel period, using a digital differential averager. A one-cycle pixel start pulse launches an internal burst sequencer. The sequencer raises a sampling strobe for a programmed number of ADC clocks during the reference pedestal. It then holds the strobe low for a programmable settle gap, around the charge-dump transition. Finally it raises the strobe for the same number of clocks during the signal pedestal.

The ADC returns each conversion a fixed number of clocks after its strobe. The block therefore carries a tag for every strobe through a delay line of the same length, so that each returning word lands in the right pedestal. Reference words are added into a wide two's-complement accumulator and signal words are subtracted. The accumulator is cleared when the pixel starts. Once the last signal word has arrived, the sum is shifted right by a programmed amount, clamped to a signed 16-bit word, and offered to an external FIFO write port. If that FIFO is full, the word is dropped and an overflow pulse is raised instead.

Top module: `dcds_pixel_accum`

## Requirements
- R1: While reset is asserted, and after it until the first accepted start, `samp_strobe`, `busy`, `fifo_wr_en` and `overflow` are all low.
- R2: After a start accepted in cycle s, with burst length B and gap G, `samp_strobe` is high in cycles s+1..s+B (reference) and in cycles s+B+G+1..s+2B+G (signal), and low otherwise. A `cfg_burst` of 0 acts as 1, and a `cfg_settle` of 0 gives no gap.
- R3: The pixel sum is the total of the reference words minus the total of the signal words, with samples taken as unsigned and the sum taken modulo 2^ACC_W (ACC_W = 20) as two's complement. The accumulator starts at zero for every pixel.
- R4: The word on `adc_data` in cycle t+ADC_LAT (ADC_LAT = 6) belongs to the strobe of cycle t. Words in all other cycles are ignored.
- R5: The written word is the pixel sum shifted arithmetically right by `cfg_shift` (0..7), then saturated to -32768..32767.
- R6: `fifo_wr_en` is high for exactly one cycle, the cycle s+2B+G+ADC_LAT+1, provided `fifo_full` is low in that cycle. `fifo_wdata` carries the pixel word in that cycle.
- R7: If `fifo_full` is high in that cycle, no write occurs and `overflow` is high for that one cycle only.
- R8: `busy` is high from cycle s+1 through the write/overflow cycle, and low otherwise. A start pulse while `busy` is high is ignored.
- R9: `cfg_burst`, `cfg_settle` and `cfg_shift` are sampled in the start cycle. Changes to them during a pixel have no effect on that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_sync | input | 1 | Pixel start pulse, accepted only when idle |
| cfg_burst | input | 8 | Samples per pedestal (0 treated as 1) |
| cfg_settle | input | 8 | Idle clocks between the two bursts |
| cfg_shift | input | 3 | Right-shift amount applied to the sum |
| adc_data | input | 12 | ADC output word, unsigned |
| samp_strobe | output | 1 | Conversion strobe to the ADC |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr_en | output | 1 | Write pulse into the FIFO |
| fifo_wdata | output | 16 | Signed pixel word |
| overflow | output | 1 | Pixel dropped because the FIFO was full |
| busy | output | 1 | Pixel in progress |

## Verification
A sequencer counter that is off by one shows up at once, as a strobe edge one cycle away from the predicted window. It also moves the write pulse, so the error is visible in the same pixel. A misaligned or wrongly signed tag, or an accumulator left uncleared, is invisible until the pixel word appears, 2B+G+7 cycles after the start. The bench therefore feeds step patterns whose reference and signal values differ, so that such errors cannot cancel out. Shift and saturation faults are exposed only by sums that are large enough, so some pixels drive full-scale pedestals at shift 0 and at shift 3.

// File: rtl/dcds_pkg.sv
package dcds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REF,
      ST_GAP,
      ST_SIG,
      ST_DRAIN,
      ST_PUSH
   } seq_state_t;

   typedef struct packed {
      logic vld;
      logic neg;
      logic last;
   } samp_tag_t;

endpackage

// File: rtl/dcds_seq.sv
module dcds_seq
   import dcds_pkg::*;
#(
   parameter int BURST_W = 8,
   parameter int GAP_W   = 8,
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_sync,
   input  logic [BURST_W-1:0] cfg_burst,
   input  logic [GAP_W-1:0]   cfg_settle,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic               drain_done,
   output logic               strobe,
   output samp_tag_t          tag,
   output logic               start,
   output logic               push,
   output logic               busy,
   output logic [SHIFT_W-1:0] shift_q
);

   localparam int CNT_W = (BURST_W > GAP_W) ? BURST_W : GAP_W;

   seq_state_t         state;
   logic [CNT_W-1:0]   cnt;
   logic [BURST_W-1:0] burst_q;
   logic [GAP_W-1:0]   settle_q;
   logic [BURST_W-1:0] burst_eff;

   assign burst_eff = (cfg_burst == '0) ? BURST_W'(1) : cfg_burst;
   assign start     = (state == ST_IDLE) && pix_sync;
   assign strobe    = (state == ST_REF) || (state == ST_SIG);
   assign busy      = (state != ST_IDLE);
   assign push      = (state == ST_PUSH);
   assign tag.vld   = strobe;
   assign tag.neg   = (state == ST_SIG);
   assign tag.last  = (state == ST_SIG) && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         burst_q  <= BURST_W'(1);
         settle_q <= '0;
         shift_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (pix_sync) begin
               burst_q  <= burst_eff;
               settle_q <= cfg_settle;
               shift_q  <= cfg_shift;
               cnt      <= CNT_W'(burst_eff) - CNT_W'(1);
               state    <= ST_REF;
            end
            ST_REF: begin
               if (cnt == '0) begin
                  if (settle_q == '0) begin
                     state <= ST_SIG;
                     cnt   <= CNT_W'(burst_q) - CNT_W'(1);
                  end else begin
                     state <= ST_GAP;
                     cnt   <= CNT_W'(settle_q) - CNT_W'(1);
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_GAP: begin
               if (cnt == '0) begin
                  state <= ST_SIG;
                  cnt   <= CNT_W'(burst_q) - CNT_W'(1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_SIG: begin
               if (cnt == '0) state <= ST_DRAIN;
               else           cnt   <= cnt - CNT_W'(1);
            end
            ST_DRAIN: if (drain_done) state <= ST_PUSH;
            ST_PUSH:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // R9: latched burst length holds for the whole pixel
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(burst_q));

   // R4: the final tag only returns while waiting for the pipeline
   a_r4_drain_only: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> (state == ST_DRAIN));

endmodule

// File: rtl/dcds_lat_pipe.sv
module dcds_lat_pipe
   import dcds_pkg::*;
#(
   parameter int ADC_LAT = 6
) (
   input  logic      clk,
   input  logic      rst_n,
   input  samp_tag_t tag_in,
   output samp_tag_t tag_out
);

   samp_tag_t stg [ADC_LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= tag_in;
   end

   for (genvar i = 1; i < ADC_LAT; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign tag_out = stg[ADC_LAT-1];

endmodule

// File: rtl/dcds_accum.sv
module dcds_accum
   import dcds_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int ACC_W    = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  samp_tag_t               tag,
   input  logic [SAMPLE_W-1:0]     sample,
   output logic signed [ACC_W-1:0] acc
);

   logic signed [ACC_W-1:0] ext;

   assign ext = $signed(ACC_W'(sample));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) acc <= '0;
      else if (tag.vld)    acc <= tag.neg ? (acc - ext) : (acc + ext);
   end

   // R3: a pixel never starts while a previous word is still arriving
   a_r3_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> !tag.vld);

endmodule

// File: rtl/dcds_scale.sv
module dcds_scale #(
   parameter int ACC_W   = 20,
   parameter int OUT_W   = 16,
   parameter int SHIFT_W = 3
) (
   input  logic signed [ACC_W-1:0] acc,
   input  logic [SHIFT_W-1:0]      shift,
   output logic [OUT_W-1:0]        word
);

   logic signed [ACC_W-1:0] shifted;

   assign shifted = acc >>> shift;

   if (ACC_W > OUT_W) begin : g_sat
      localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2**(OUT_W-1)) - 1);
      localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
      always_comb begin
         if (shifted > MAXV)      word = MAXV[OUT_W-1:0];
         else if (shifted < MINV) word = MINV[OUT_W-1:0];
         else                     word = shifted[OUT_W-1:0];
      end
   end else begin : g_pass
      assign word = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/dcds_pixel_accum.sv
module dcds_pixel_accum
   import dcds_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int ACC_W    = 20,
   parameter int OUT_W    = 16,
   parameter int BURST_W  = 8,
   parameter int GAP_W    = 8,
   parameter int SHIFT_W  = 3,
   parameter int ADC_LAT  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pix_sync,
   input  logic [BURST_W-1:0]  cfg_burst,
   input  logic [GAP_W-1:0]    cfg_settle,
   input  logic [SHIFT_W-1:0]  cfg_shift,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic                samp_strobe,
   input  logic                fifo_full,
   output logic                fifo_wr_en,
   output logic [OUT_W-1:0]    fifo_wdata,
   output logic                overflow,
   output logic                busy
);

   if (ADC_LAT < 1) begin : g_bad_lat
      $error("ADC_LAT must be at least 1");
   end
   if (ACC_W <= SAMPLE_W) begin : g_bad_acc
      $error("ACC_W must exceed SAMPLE_W");
   end
   if (ACC_W < OUT_W) begin : g_bad_out
      $error("OUT_W may not exceed ACC_W");
   end

   samp_tag_t               tag_now;
   samp_tag_t               tag_back;
   logic                    start;
   logic                    push;
   logic [SHIFT_W-1:0]      shift_q;
   logic signed [ACC_W-1:0] acc;

   dcds_seq #(.BURST_W(BURST_W), .GAP_W(GAP_W), .SHIFT_W(SHIFT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_sync   (pix_sync),
      .cfg_burst  (cfg_burst),
      .cfg_settle (cfg_settle),
      .cfg_shift  (cfg_shift),
      .drain_done (tag_back.vld && tag_back.last),
      .strobe     (samp_strobe),
      .tag        (tag_now),
      .start      (start),
      .push       (push),
      .busy       (busy),
      .shift_q    (shift_q)
   );

   dcds_lat_pipe #(.ADC_LAT(ADC_LAT)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .tag_in  (tag_now),
      .tag_out (tag_back)
   );

   dcds_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .tag    (tag_back),
      .sample (adc_data),
      .acc    (acc)
   );

   dcds_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_scale (
      .acc   (acc),
      .shift (shift_q),
      .word  (fifo_wdata)
   );

   assign fifo_wr_en = push && !fifo_full;
   assign overflow   = push && fifo_full;

   // R2: no conversion is requested outside a pixel
   a_r2_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      samp_strobe |-> busy);

   // R6: one write per pixel
   a_r6_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |=> !fifo_wr_en);

   // R7: write or drop ends the pixel
   a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_en || overflow) |=> !busy);

   // R8: a pixel only begins after a start pulse
   a_r8_busy_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(pix_sync));

   // R3: the sum is empty on the first busy cycle
   a_r3_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (acc == '0));

endmodule

// File: tb/dcds_pixel_accum_tb.sv
`timescale 1ns/1ps
module dcds_pixel_accum_tb;

   localparam int LAT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_sync = 1'b0;
   logic [7:0]  cfg_burst = '0;
   logic [7:0]  cfg_settle = '0;
   logic [2:0]  cfg_shift = '0;
   logic [11:0] adc_data = '0;
   logic        fifo_full = 1'b0;
   logic        samp_strobe, fifo_wr_en, overflow, busy;
   logic [15:0] fifo_wdata;

   always #2.5 clk = ~clk;

   dcds_pixel_accum u_dut (
      .clk(clk), .rst_n(rst_n), .pix_sync(pix_sync), .cfg_burst(cfg_burst),
      .cfg_settle(cfg_settle), .cfg_shift(cfg_shift), .adc_data(adc_data),
      .samp_strobe(samp_strobe), .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en),
      .fifo_wdata(fifo_wdata), .overflow(overflow), .busy(busy)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit finished = 0;
   bit rq_sync = 0, rq_full = 0, forced = 0;
   int rq_b = 1, rq_g = 0, rq_sh = 0, hiv = 0, lov = 0;
   bit have = 0;
   int ms = 0, mB = 1, mG = 0, mSH = 0, mp = 0;
   int vhist [1024];

   function automatic bit e_ref(int c);
      return have && c >= ms + 1 && c <= ms + mB;
   endfunction
   function automatic bit e_sig(int c);
      return have && c >= ms + mB + mG + 1 && c <= ms + 2*mB + mG;
   endfunction
   function automatic bit e_busy(int c);
      return have && c >= ms + 1 && c <= mp;
   endfunction

   function automatic int e_word();
      int s = 0;
      int w;
      for (int t = ms + 1; t <= ms + mB; t++) s += vhist[t % 1024];
      for (int t = ms + mB + mG + 1; t <= ms + 2*mB + mG; t++) s -= vhist[t % 1024];
      w = s & 32'hFFFFF;
      if (w >= 524288) w -= 1048576;
      w = w >>> mSH;
      if (w > 32767) w = 32767;
      if (w < -32768) w = -32768;
      return w;
   endfunction

   task automatic cmp(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: got %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic step();
      int v;
      @(posedge clk);
      cyc++;
      #1;
      pix_sync   = rq_sync;
      fifo_full  = rq_full;
      cfg_burst  = rq_b[7:0];
      cfg_settle = rq_g[7:0];
      cfg_shift  = rq_sh[2:0];
      if (rst_n && rq_sync && !e_busy(cyc)) begin
         have = 1; ms = cyc;
         mB = (rq_b == 0) ? 1 : rq_b; mG = rq_g; mSH = rq_sh;
         mp = ms + 2*mB + mG + LAT + 1;
      end
      v = $urandom_range(4095);
      if (forced && e_ref(cyc)) v = hiv;
      if (forced && e_sig(cyc)) v = lov;
      vhist[cyc % 1024] = v;
      adc_data = (cyc >= LAT) ? 12'(vhist[(cyc - LAT) % 1024]) : 12'h0;
      #2;
      if (!rst_n) begin
         cmp("R1 strobe", samp_strobe, 0);
         cmp("R1 busy", busy, 0);
         cmp("R1 wr", fifo_wr_en, 0);
         cmp("R1 ovf", overflow, 0);
      end else begin
         cmp("R2 strobe", samp_strobe, e_ref(cyc) || e_sig(cyc));
         cmp("R8 busy", busy, e_busy(cyc));
         cmp("R6 wr", fifo_wr_en, have && cyc == mp && !rq_full);
         cmp("R7 ovf", overflow, have && cyc == mp && rq_full);
         if (have && cyc == mp && !rq_full)
            cmp("R3 R4 R5 R9 word", int'($signed(fifo_wdata)), e_word());
      end
   endtask

   task automatic run_pixel(int b, int g, int sh, bit full, bit frc, int hi, int lo);
      rq_b = b; rq_g = g; rq_sh = sh; rq_full = full;
      forced = frc; hiv = hi; lov = lo;
      rq_sync = 1; step(); rq_sync = 0;
      while (cyc < mp) step();
      rq_full = 0;
      step();
   endtask

   initial begin
      repeat (3) step();               // R1 during reset
      rst_n = 1;
      repeat (2) step();               // R1 after reset, no start
      run_pixel(4, 3, 0, 0, 0, 0, 0);  // R2 R3 random
      run_pixel(1, 0, 2, 0, 0, 0, 0);  // R2 single pair, no gap
      run_pixel(0, 5, 1, 0, 0, 0, 0);  // R2 zero burst acts as one
      run_pixel(40, 2, 0, 0, 1, 4095, 0);  // R5 positive saturation
      run_pixel(40, 2, 0, 0, 1, 0, 4095);  // R5 negative saturation
      run_pixel(40, 2, 3, 0, 1, 4095, 0);  // R5 shift without clamp
      run_pixel(7, 1, 0, 0, 1, 100, 4000); // R3 R4 sign and alignment
      run_pixel(255, 255, 7, 0, 0, 0, 0);  // R2 longest bursts
      run_pixel(3, 2, 0, 1, 0, 0, 0);      // R7 dropped pixel
      // R8 R9: start and config changes during a pixel are ignored
      rq_b = 6; rq_g = 2; rq_sh = 1; forced = 0;
      rq_sync = 1; step(); rq_sync = 0;
      repeat (3) step();
      rq_sync = 1; rq_b = 9; rq_g = 0; rq_sh = 5;
      repeat (2) step();
      rq_sync = 0;
      while (cyc < mp - 1) step();
      rq_sync = 1; step();  // cycle mp: ignored (R8)
      step();               // cycle mp+1: accepted
      rq_sync = 0;
      while (cyc < mp) step();
      repeat (2) step();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule